// File: doc/BRIEF.md
# Priority-Masking Nested Interrupt Sequencer

This block sits next to a flat interrupt controller whose lines are switched on and off through separate set-enable and clear-enable masks. It gives that controller nesting by priority. Every input line carries a 4-bit priority, where a larger number means a more urgent line. For each level the block keeps a precomputed set of lines that must be blocked while an interrupt of that level is in service. Those sets are the enabled lines whose priority is at or below the level.

The block takes an accept request together with the controller's masked status word. It picks the lowest-numbered pending line and pulses a clear-enable mask holding that line's level set. It returns the level that was current before, as a token, and makes the line's priority the current level. The caller keeps the token. On end-of-interrupt the caller hands the token back. The block then restores that level and pulses a set-enable mask that brings back only lines that are enabled overall and are not blocked at the restored level. There is no hardware priority comparator: all nesting comes from the stored sets.

Top module: `nest_irq_seq`

## Requirements
- R1: Reset clears all level sets, the enabled set and every stored line priority, and makes the current level 0. In the first cycle after reset is released, a clear-enable pulse with all bits set goes out. Any request in that cycle is dropped.
- R2: A valid configure that enables line L at priority P outputs a set-enable pulse whose only set bit is bit L. It stores P for line L, adds L to the enabled set and to the sets of levels P through 15, and removes L from the sets of levels below P.
- R3: A valid configure that disables line L outputs a clear-enable pulse whose only set bit is bit L. It removes L from the enabled set and from all 16 level sets.
- R4: A configure with a line index of 32 or more (6-bit field) or a priority above 15 (5-bit field) gives a one-cycle error pulse. It produces no enable or disable pulse and changes no state.
- R5: An accept with a zero status word gives an ack with the none flag set. It produces no clear-enable pulse and leaves the current level unchanged.
- R6: An accept with a nonzero status word reports the index of the lowest set status bit as the firing line.
- R7: On a line-firing accept, the block pulses a clear-enable mask equal to the set of the firing line's stored priority. It returns the old current level as the token and makes the firing line's priority the current level.
- R8: An end-of-interrupt with token T makes T the current level. It pulses a set-enable mask equal to the enabled set ANDed with the complement of level T's set.
- R9: Only one request is handled per clock. Configure wins over end-of-interrupt, and end-of-interrupt wins over accept. Losing requests are dropped without any response.
- R10: All results appear in registers one cycle after the request and last exactly one cycle. A set-enable pulse and a clear-enable pulse never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configure request pulse |
| cfg_line | input | 6 | Line index to configure |
| cfg_prio | input | 5 | Priority for an enable configure |
| cfg_enable | input | 1 | 1 = enable line, 0 = disable line |
| cfg_err | output | 1 | Rejected configure pulse |
| acc_valid | input | 1 | Accept request pulse |
| status_in | input | 32 | Masked status word from the flat controller |
| acc_ack | output | 1 | Accept response pulse |
| acc_none | output | 1 | No pending line on this accept |
| acc_line | output | 5 | Firing line index |
| acc_token | output | 4 | Level current before the accept |
| eoi_valid | input | 1 | End-of-interrupt request pulse |
| eoi_token | input | 4 | Level to restore |
| en_valid | output | 1 | Set-enable pulse |
| en_mask | output | 32 | Lines to enable |
| dis_valid | output | 1 | Clear-enable pulse |
| dis_mask | output | 32 | Lines to disable |
| cur_level | output | 4 | Current priority level |

## Verification
The assertions assume that every request is a single-cycle pulse. They also assume that the status word is stable during the cycle in which an accept is sampled, and that tokens come back exactly as the block issued them. The stimulus drives every request for exactly one cycle on the falling edge. It returns each token as received, and holds requests off during the initialization cycle after reset. Collisions are created on purpose and only between the request kinds whose priority the ordering rule defines.

// File: rtl/nest_pkg.sv
package nest_pkg;

    localparam int DEF_LINES  = 32;
    localparam int DEF_LEVELS = 16;

    typedef enum logic [2:0] {
        NS_IDLE,
        NS_INIT,
        NS_CFG,
        NS_CFG_BAD,
        NS_EOI,
        NS_ACC
    } ns_cmd_e;

    // Fixed ordering: init, configure, end-of-interrupt, accept.
    function automatic ns_cmd_e choose_cmd(input logic init_p,
                                           input logic cfg_v,
                                           input logic cfg_ok,
                                           input logic eoi_v,
                                           input logic acc_v);
        if (init_p)      return NS_INIT;
        else if (cfg_v)  return cfg_ok ? NS_CFG : NS_CFG_BAD;
        else if (eoi_v)  return NS_EOI;
        else if (acc_v)  return NS_ACC;
        else             return NS_IDLE;
    endfunction

endpackage

// File: rtl/nest_pick.sv
module nest_pick #(
    parameter int LINES = nest_pkg::DEF_LINES,
    localparam int LIDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0]  vec,
    output logic              found,
    output logic [LIDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = LIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/nest_mask_table.sv
module nest_mask_table #(
    parameter int LINES  = nest_pkg::DEF_LINES,
    parameter int LEVELS = nest_pkg::DEF_LEVELS,
    localparam int LIDX_W = $clog2(LINES),
    localparam int PRIO_W = $clog2(LEVELS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           wr_set,
    input  logic [LIDX_W-1:0]              wr_line,
    input  logic [PRIO_W-1:0]              wr_prio,
    input  logic [LIDX_W-1:0]              sel_line,
    output logic [PRIO_W-1:0]              sel_prio,
    output logic [LEVELS-1:0][LINES-1:0]   level_sets,
    output logic [LINES-1:0]               enabled
);
    logic [PRIO_W-1:0] prio_q [LINES];

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        always_ff @(posedge clk) begin
            if (rst) begin
                level_sets[lv] <= '0;
            end else if (wr_en) begin
                level_sets[lv][wr_line] <= wr_set && (PRIO_W'(lv) >= wr_prio);
            end
        end
    end

    for (genvar ln = 0; ln < LINES; ln++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q[ln]  <= '0;
                enabled[ln] <= 1'b0;
            end else if (wr_en && (wr_line == LIDX_W'(ln))) begin
                enabled[ln] <= wr_set;
                if (wr_set) prio_q[ln] <= wr_prio;
            end
        end
    end

    assign sel_prio = prio_q[sel_line];
endmodule

// File: rtl/nest_irq_seq.sv
module nest_irq_seq #(
    parameter int LINES  = nest_pkg::DEF_LINES,
    parameter int LEVELS = nest_pkg::DEF_LEVELS,
    localparam int LIDX_W = $clog2(LINES),
    localparam int PRIO_W = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [LIDX_W:0]   cfg_line,
    input  logic [PRIO_W:0]   cfg_prio,
    input  logic              cfg_enable,
    output logic              cfg_err,
    input  logic              acc_valid,
    input  logic [LINES-1:0]  status_in,
    output logic              acc_ack,
    output logic              acc_none,
    output logic [LIDX_W-1:0] acc_line,
    output logic [PRIO_W-1:0] acc_token,
    input  logic              eoi_valid,
    input  logic [PRIO_W-1:0] eoi_token,
    output logic              en_valid,
    output logic [LINES-1:0]  en_mask,
    output logic              dis_valid,
    output logic [LINES-1:0]  dis_mask,
    output logic [PRIO_W-1:0] cur_level
);
    import nest_pkg::*;

    logic                         init_pend;
    logic                         cfg_ok;
    ns_cmd_e                      cmd;
    logic                         pick_found;
    logic [LIDX_W-1:0]            pick_idx;
    logic [PRIO_W-1:0]            pick_prio;
    logic [LEVELS-1:0][LINES-1:0] level_sets;
    logic [LINES-1:0]             enabled;
    logic [LINES-1:0]             cfg_bit;

    assign cfg_ok  = (cfg_line < (LIDX_W+1)'(LINES)) && (cfg_prio < (PRIO_W+1)'(LEVELS));
    assign cmd     = choose_cmd(init_pend, cfg_valid, cfg_ok, eoi_valid, acc_valid);
    assign cfg_bit = LINES'(1) << cfg_line[LIDX_W-1:0];

    nest_pick #(.LINES(LINES)) pick_i (
        .vec   (status_in),
        .found (pick_found),
        .idx   (pick_idx)
    );

    nest_mask_table #(.LINES(LINES), .LEVELS(LEVELS)) table_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cmd == NS_CFG),
        .wr_set     (cfg_enable),
        .wr_line    (cfg_line[LIDX_W-1:0]),
        .wr_prio    (cfg_prio[PRIO_W-1:0]),
        .sel_line   (pick_idx),
        .sel_prio   (pick_prio),
        .level_sets (level_sets),
        .enabled    (enabled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            init_pend <= 1'b1;
            cur_level <= '0;
            cfg_err   <= 1'b0;
            acc_ack   <= 1'b0;
            acc_none  <= 1'b0;
            acc_line  <= '0;
            acc_token <= '0;
            en_valid  <= 1'b0;
            en_mask   <= '0;
            dis_valid <= 1'b0;
            dis_mask  <= '0;
        end else begin
            cfg_err   <= 1'b0;
            acc_ack   <= 1'b0;
            acc_none  <= 1'b0;
            en_valid  <= 1'b0;
            dis_valid <= 1'b0;
            case (cmd)
                NS_INIT: begin
                    init_pend <= 1'b0;
                    cur_level <= '0;
                    dis_valid <= 1'b1;
                    dis_mask  <= '1;
                end
                NS_CFG: begin
                    if (cfg_enable) begin
                        en_valid <= 1'b1;
                        en_mask  <= cfg_bit;
                    end else begin
                        dis_valid <= 1'b1;
                        dis_mask  <= cfg_bit;
                    end
                end
                NS_CFG_BAD: cfg_err <= 1'b1;
                NS_EOI: begin
                    cur_level <= eoi_token;
                    en_valid  <= 1'b1;
                    en_mask   <= ~level_sets[eoi_token] & enabled;
                end
                NS_ACC: begin
                    acc_ack <= 1'b1;
                    if (!pick_found) begin
                        acc_none  <= 1'b1;
                        acc_line  <= '0;
                        acc_token <= '0;
                    end else begin
                        acc_line  <= pick_idx;
                        acc_token <= cur_level;
                        cur_level <= pick_prio;
                        dis_valid <= 1'b1;
                        dis_mask  <= level_sets[pick_prio];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nest_irq_seq_chk.sv
module nest_irq_seq_chk #(
    parameter int LINES  = nest_pkg::DEF_LINES,
    parameter int LEVELS = nest_pkg::DEF_LEVELS,
    localparam int LIDX_W = $clog2(LINES),
    localparam int PRIO_W = $clog2(LEVELS)
) (
    input logic              clk,
    input logic              rst,
    input logic              init_pend,
    input logic              cfg_valid,
    input logic [LIDX_W:0]   cfg_line,
    input logic [PRIO_W:0]   cfg_prio,
    input logic              cfg_enable,
    input logic              cfg_err,
    input logic              acc_valid,
    input logic [LINES-1:0]  status_in,
    input logic              acc_ack,
    input logic              acc_none,
    input logic [LIDX_W-1:0] acc_line,
    input logic [PRIO_W-1:0] acc_token,
    input logic              eoi_valid,
    input logic [PRIO_W-1:0] eoi_token,
    input logic              en_valid,
    input logic [LINES-1:0]  en_mask,
    input logic              dis_valid,
    input logic [LINES-1:0]  dis_mask,
    input logic [PRIO_W-1:0] cur_level
);
    AST_INIT_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        init_pend |=> (dis_valid && (&dis_mask)));  // R1

    AST_CFG_EN_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (!init_pend && cfg_valid && cfg_enable && (cfg_line < (LIDX_W+1)'(LINES))
         && (cfg_prio < (PRIO_W+1)'(LEVELS)))
        |=> (en_valid && ($countones(en_mask) == 1)));  // R2

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!en_valid && !dis_valid && !acc_ack));  // R4

    AST_NONE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_ack && acc_none) |-> (($past(status_in) == '0) && !dis_valid));  // R5

    AST_LINE_PENDING: assert property (@(posedge clk) disable iff (rst)
        (acc_ack && !acc_none) |-> ((($past(status_in) >> acc_line) & LINES'(1)) != '0));  // R6

    AST_LINE_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (acc_ack && !acc_none) |-> (($past(status_in) & ((LINES'(1) << acc_line) - LINES'(1))) == '0));  // R6

    AST_TOKEN_OLD_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (acc_ack && !acc_none) |-> (acc_token == $past(cur_level)));  // R7

    AST_EOI_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (!init_pend && !cfg_valid && eoi_valid) |=> (cur_level == $past(eoi_token)));  // R8

    AST_ACC_SERVED: assert property (@(posedge clk) disable iff (rst)
        (!init_pend && !cfg_valid && !eoi_valid && acc_valid) |=> acc_ack);  // R9

    AST_ACC_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid || eoi_valid || init_pend) |=> !acc_ack);  // R9

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(en_valid && dis_valid));  // R10
endmodule

bind nest_irq_seq nest_irq_seq_chk #(.LINES(LINES), .LEVELS(LEVELS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .init_pend  (init_pend),
    .cfg_valid  (cfg_valid),
    .cfg_line   (cfg_line),
    .cfg_prio   (cfg_prio),
    .cfg_enable (cfg_enable),
    .cfg_err    (cfg_err),
    .acc_valid  (acc_valid),
    .status_in  (status_in),
    .acc_ack    (acc_ack),
    .acc_none   (acc_none),
    .acc_line   (acc_line),
    .acc_token  (acc_token),
    .eoi_valid  (eoi_valid),
    .eoi_token  (eoi_token),
    .en_valid   (en_valid),
    .en_mask    (en_mask),
    .dis_valid  (dis_valid),
    .dis_mask   (dis_mask),
    .cur_level  (cur_level)
);

// File: tb/nest_irq_seq_tb.sv
`timescale 1ns/1ps
module nest_irq_seq_tb_top;
    localparam int LINES = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_valid, cfg_enable, acc_valid, eoi_valid;
    logic [5:0]  cfg_line;
    logic [4:0]  cfg_prio;
    logic [31:0] status_in;
    logic [3:0]  eoi_token;
    logic        cfg_err, acc_ack, acc_none, en_valid, dis_valid;
    logic [4:0]  acc_line;
    logic [3:0]  acc_token, cur_level;
    logic [31:0] en_mask, dis_mask;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state
    logic [3:0]  ref_prio [LINES];
    logic [31:0] ref_en;
    logic [3:0]  ref_level;
    // expected outputs
    logic        x_err, x_ack, x_none, x_en_v, x_dis_v;
    logic [4:0]  x_line;
    logic [3:0]  x_tok;
    logic [31:0] x_en_m, x_dis_m;

    always #5 clk = ~clk;

    nest_irq_seq dut_i (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_line(cfg_line), .cfg_prio(cfg_prio),
        .cfg_enable(cfg_enable), .cfg_err(cfg_err),
        .acc_valid(acc_valid), .status_in(status_in),
        .acc_ack(acc_ack), .acc_none(acc_none), .acc_line(acc_line), .acc_token(acc_token),
        .eoi_valid(eoi_valid), .eoi_token(eoi_token),
        .en_valid(en_valid), .en_mask(en_mask),
        .dis_valid(dis_valid), .dis_mask(dis_mask),
        .cur_level(cur_level)
    );

    function automatic logic [31:0] blocked_at(input int lvl);
        logic [31:0] m = '0;
        for (int i = 0; i < LINES; i++)
            if (ref_en[i] && (int'(ref_prio[i]) <= lvl)) m[i] = 1'b1;
        return m;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(req, "cfg_err", 32'(cfg_err), 32'(x_err));
        chk(req, "acc_ack", 32'(acc_ack), 32'(x_ack));
        chk(req, "en_valid", 32'(en_valid), 32'(x_en_v));
        chk(req, "dis_valid", 32'(dis_valid), 32'(x_dis_v));
        chk(req, "cur_level", 32'(cur_level), 32'(ref_level));
        if (x_ack) chk(req, "acc_none", 32'(acc_none), 32'(x_none));
        if (x_ack && !x_none) begin
            chk(req, "acc_line", 32'(acc_line), 32'(x_line));
            chk(req, "acc_token", 32'(acc_token), 32'(x_tok));
        end
        if (x_en_v)  chk(req, "en_mask", en_mask, x_en_m);
        if (x_dis_v) chk(req, "dis_mask", dis_mask, x_dis_m);
    endtask

    // One cycle of requests; model computes expectations, outputs checked after.
    task automatic req(input string tag,
                       input bit cv, input int ln, input int pr, input bit ce,
                       input bit av, input logic [31:0] st,
                       input bit ev, input int tk);
        @(negedge clk);
        cfg_valid = cv; cfg_line = 6'(ln); cfg_prio = 5'(pr); cfg_enable = ce;
        acc_valid = av; status_in = st;
        eoi_valid = ev; eoi_token = 4'(tk);
        x_err = 0; x_ack = 0; x_none = 0; x_en_v = 0; x_dis_v = 0;
        x_line = '0; x_tok = '0; x_en_m = '0; x_dis_m = '0;
        if (cv) begin
            if (ln >= LINES || pr > 15) x_err = 1;
            else if (ce) begin
                x_en_v = 1; x_en_m = 32'd1 << ln;
                ref_en[ln] = 1'b1; ref_prio[ln] = 4'(pr);
            end else begin
                x_dis_v = 1; x_dis_m = 32'd1 << ln;
                ref_en[ln] = 1'b0;
            end
        end else if (ev) begin
            ref_level = 4'(tk);
            x_en_v = 1; x_en_m = ~blocked_at(tk) & ref_en;
        end else if (av) begin
            x_ack = 1;
            if (st == 0) x_none = 1;
            else begin
                int f = 0;
                while (!st[f]) f++;
                x_line = 5'(f);
                x_tok = ref_level;
                x_dis_v = 1; x_dis_m = blocked_at(int'(ref_prio[f]));
                ref_level = ref_prio[f];
            end
        end
        @(negedge clk);
        cfg_valid = 0; acc_valid = 0; eoi_valid = 0;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] t1, t2;
        cfg_valid = 0; acc_valid = 0; eoi_valid = 0; cfg_enable = 0;
        cfg_line = '0; cfg_prio = '0; status_in = '0; eoi_token = '0;
        for (int i = 0; i < LINES; i++) ref_prio[i] = '0;
        ref_en = '0; ref_level = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: init pulse
        chk("R1", "init dis_valid", 32'(dis_valid), 32'd1);
        chk("R1", "init dis_mask", dis_mask, 32'hFFFF_FFFF);
        chk("R1", "init en_valid", 32'(en_valid), 32'd0);
        chk("R1", "init level", 32'(cur_level), 32'd0);
        @(negedge clk);
        // R10: pulse lasts one cycle
        chk("R10", "init pulse width", 32'(dis_valid), 32'd0);
        // R1: sets empty after reset
        req("R1", 0,0,0,0, 1, 32'h0000_0010, 0,0);
        req("R8", 0,0,0,0, 0, 0, 1, 0);

        // R2: enable every line, priority spread across levels
        for (int i = 0; i < LINES; i++) req("R2", 1, i, (i*5) % 16, 1, 0, 0, 0, 0);

        // R6 R7 R8: each line fires with all higher lines also pending
        for (int i = 0; i < LINES; i++) begin
            logic [31:0] st = 32'hFFFF_FFFF << i;
            req("R7", 0,0,0,0, 1, st, 0,0);
            req("R8", 0,0,0,0, 0, 0, 1, int'(acc_token));
        end
        // R6: sparse patterns
        req("R6", 0,0,0,0, 1, 32'h8000_0100, 0,0);
        req("R8", 0,0,0,0, 0, 0, 1, int'(acc_token));
        req("R6", 0,0,0,0, 1, 32'h8000_0000, 0,0);
        req("R8", 0,0,0,0, 0, 0, 1, int'(acc_token));

        // R7: nesting two deep
        req("R7", 0,0,0,0, 1, 32'h0000_0200, 0,0);
        t1 = acc_token;
        req("R7", 0,0,0,0, 1, 32'h0000_0004, 0,0);
        t2 = acc_token;
        req("R8", 0,0,0,0, 0, 0, 1, int'(t2));
        req("R8", 0,0,0,0, 0, 0, 1, int'(t1));

        // R3: disable lines, then observe their absence
        req("R3", 1, 5, 0, 0, 0, 0, 0, 0);
        req("R3", 1, 17, 0, 0, 0, 0, 0, 0);
        req("R3", 0,0,0,0, 1, 32'h0010_0000, 0,0);
        req("R3", 0,0,0,0, 0, 0, 1, int'(acc_token));
        req("R3", 0,0,0,0, 0, 0, 1, 15);
        req("R3", 0,0,0,0, 0, 0, 1, 0);

        // R4: rejected configures, then state probes
        req("R4", 1, 32, 3, 1, 0, 0, 0, 0);
        req("R4", 1, 40, 3, 0, 0, 0, 0, 0);
        req("R4", 1, 3, 16, 1, 0, 0, 0, 0);
        req("R4", 1, 3, 31, 1, 0, 0, 0, 0);
        req("R4", 0,0,0,0, 1, 32'h0000_0008, 0,0);
        req("R4", 0,0,0,0, 0, 0, 1, 15);
        req("R4", 0,0,0,0, 0, 0, 1, 0);

        // R5: zero status
        req("R5", 0,0,0,0, 0, 0, 1, 9);
        req("R5", 0,0,0,0, 1, 32'h0, 0,0);
        req("R5", 0,0,0,0, 0, 0, 1, 0);

        // R9: collisions
        req("R9", 1, 5, 7, 1, 1, 32'h1, 0, 0);
        req("R9", 0,0,0,0, 1, 32'h2, 1, 6);
        req("R9", 1, 5, 2, 1, 0, 0, 1, 11);
        req("R9", 1, 9, 0, 0, 1, 32'h4, 1, 3);
        req("R2", 0,0,0,0, 1, 32'h20, 0,0);
        req("R8", 0,0,0,0, 0, 0, 1, 12);
        req("R8", 0,0,0,0, 0, 0, 1, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule